// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block is a synchronous master for a 10 ns asynchronous static RAM organised as words with two byte lanes. On the user side a client presents a single-word request: a write flag, an address, write data and a byte-lane mask. The controller turns the request into a pin sequence on the memory side that meets the memory's nanosecond minimums and maximums. Every phase length is computed at elaboration time from a clock-period parameter and the memory's timing figures. Each length is the ceiling of the required time divided by the clock period, with a floor of one cycle.

After reset the controller holds all strobes inactive for the power-up hold-off of at least 100 µs. It then sits in an idle state with the ready output high. A read drives chip select, output enable and the selected lane enables for the read phase. It registers the returned data on the last cycle of that phase and then spends a turnaround phase with output enable high before returning to idle. A write keeps output enable high throughout. It drives the data bus and pulses write enable low for the write phase, then holds address, lanes and data for at least one more cycle with write enable high. That hold is stretched, if needed, so the whole write meets the minimum write cycle time.

States: `ST_PWRUP` (hold-off), `ST_IDLE`, `ST_READ`, `ST_TURN` (bus release after a read), `ST_WPULSE` (write enable low), `ST_WHOLD` (write enable high, bus still driven). Transitions:
- PWRUP to IDLE when the hold-off count expires.
- IDLE to READ on an accepted request with the write flag clear.
- IDLE to WPULSE on an accepted request with the write flag set.
- READ to TURN at the end of the read phase.
- TURN to IDLE at the end of the turnaround.
- WPULSE to WHOLD at the end of the pulse.
- WHOLD to IDLE at the end of the hold.

Top module: `sram_ctl`

## Requirements
- R1: After reset release, `usr_ready` stays low and chip select, write enable and output enable stay high for PWR_CYC = ceil(100 µs / Tclk) clock edges (12500 at 8 ns). `usr_ready` is high after exactly that many edges.
- R2: A read holds chip select and output enable low and write enable high for RD_CYC = ceil(max(10, 10, 5 ns) / Tclk) cycles (2 at 8 ns). The data on `mem_din` is registered on the last of those cycles. `usr_rvalid` pulses for one cycle, RD_CYC+1 falling edges after the falling edge at which the request met `usr_ready`.
- R3: Mask bit 0 selects bits 7:0 and mask bit 1 selects bits 15:8. During a read, a lane enable (active low) is driven low only for a set mask bit. A lane whose mask bit is clear reads back as zero in `usr_rdata`.
- R4: During a write, write enable is low for WP_CYC = ceil(max(7, 7, 7, 7, 5 ns) / Tclk) cycles (1 at 8 ns). Throughout the pulse, chip select is low, output enable is high and `mem_dout_en` is high.
- R5: After write enable rises, address, lane enables and write data stay unchanged and driven, with chip select low, for WH_CYC = max(1, ceil(10 ns / Tclk) − WP_CYC) cycles. `usr_ready` returns WP_CYC+WH_CYC edges after acceptance.
- R6: A write changes only the lanes whose mask bit is set. A byte in a lane whose mask bit is clear keeps its previous content.
- R7: `mem_dout_en` is never high while output enable is low. After a read, output enable stays high for TURN_CYC = ceil(5 ns / Tclk) cycles (1 at 8 ns) before the controller is ready again.
- R8: A request is accepted only on a clock edge at which both `usr_req` and `usr_ready` are high. A request raised while `usr_ready` is low and dropped before it returns has no effect on the memory or on the bus.
- R9: While `usr_ready` is high, all memory strobes and lane enables are inactive (high) and `mem_dout_en` is low.
- R10: While `rst_n` is low, `usr_ready` and `usr_rvalid` are low, the strobes are high and `mem_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | Access request |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | 17 | Word address |
| usr_wdata | input | 16 | Write data |
| usr_mask | input | 2 | Byte-lane mask, bit 0 = low byte |
| usr_ready | output | 1 | Idle; a request is taken on this edge |
| usr_rdata | output | 16 | Read data, masked lanes zero |
| usr_rvalid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte-lane enables, active low |
| mem_dout | output | 16 | Data toward the memory |
| mem_dout_en | output | 1 | Controller drives the data bus |
| mem_din | input | 16 | Data from the memory |

## Verification
The end of a read's turnaround and the start of a following write can meet: the controller returns to idle, and the next request is taken in the same cycle. If the turnaround were skipped, the data drivers would switch on while the memory still owns the bus. The bench provokes this by presenting the next request at the very falling edge where ready returns, in directed read-then-write pairs and in a random stream of mixed reads and writes. A pin monitor judges the result: it flags any cycle with the data driver on while output enable is low, and it measures the output-enable-high gap before each drive. Read-back data is compared against a bench shadow memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_READ   = 3'd2,
        ST_TURN   = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } ctl_state_t;

    // ceiling division for positive operands
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Loadable down counter; done is high when the count has reached zero.
module sram_ctl_timer #(
    parameter int CNT_W = 8,
    parameter int INIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
// Per-lane enable generation and read-data lane filtering.
module sram_ctl_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              active,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] din,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] din_kept
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = ~(active & mask[g]);
        assign din_kept[g*LANE_W +: LANE_W] =
            mask[g] ? din[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int LANES      = 2,
    parameter int LANE_W     = 8,
    parameter int T_CLK_PS   = 8000,
    parameter int T_RC_PS    = 10000,
    parameter int T_AA_PS    = 10000,
    parameter int T_DOE_PS   = 5000,
    parameter int T_WC_PS    = 10000,
    parameter int T_PWE_PS   = 7000,
    parameter int T_SCE_PS   = 7000,
    parameter int T_AW_PS    = 7000,
    parameter int T_BW_PS    = 7000,
    parameter int T_SD_PS    = 5000,
    parameter int T_HZ_PS    = 5000,
    parameter int T_PWRUP_PS = 100_000_000,
    localparam int DATA_W    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_req,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [LANES-1:0]  usr_mask,
    output logic              usr_ready,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    // phase lengths in clock cycles, each at least one
    localparam int RD_CYC = max2(1, max2(cdiv(T_RC_PS, T_CLK_PS),
                                 max2(cdiv(T_AA_PS, T_CLK_PS), cdiv(T_DOE_PS, T_CLK_PS))));
    localparam int TURN_CYC = max2(1, cdiv(T_HZ_PS, T_CLK_PS));
    localparam int WP_CYC = max2(1, max2(max2(cdiv(T_PWE_PS, T_CLK_PS), cdiv(T_SCE_PS, T_CLK_PS)),
                                 max2(max2(cdiv(T_AW_PS, T_CLK_PS), cdiv(T_BW_PS, T_CLK_PS)),
                                      cdiv(T_SD_PS, T_CLK_PS))));
    localparam int WH_CYC   = max2(1, cdiv(T_WC_PS, T_CLK_PS) - WP_CYC);
    localparam int PWR_CYC  = max2(1, cdiv(T_PWRUP_PS, T_CLK_PS));
    localparam int CNT_MAX  = max2(max2(PWR_CYC, RD_CYC), max2(max2(TURN_CYC, WP_CYC), WH_CYC));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    ctl_state_t        state_q, state_nx;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    logic              lane_act;
    logic [DATA_W-1:0] din_kept;

    assign accept = (state_q == ST_IDLE) && usr_req;

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_PWRUP:  if (tmr_done) state_nx = ST_IDLE;
            ST_IDLE:   if (usr_req)  state_nx = usr_we ? ST_WPULSE : ST_READ;
            ST_READ:   if (tmr_done) state_nx = ST_TURN;
            ST_TURN:   if (tmr_done) state_nx = ST_IDLE;
            ST_WPULSE: if (tmr_done) state_nx = ST_WHOLD;
            ST_WHOLD:  if (tmr_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // phase length loaded on every state change
    always_comb begin
        tmr_load = (state_nx != state_q);
        tmr_val  = '0;
        unique case (state_nx)
            ST_READ:   tmr_val = CNT_W'(RD_CYC - 1);
            ST_TURN:   tmr_val = CNT_W'(TURN_CYC - 1);
            ST_WPULSE: tmr_val = CNT_W'(WP_CYC - 1);
            ST_WHOLD:  tmr_val = CNT_W'(WH_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    sram_ctl_timer #(
        .CNT_W (CNT_W),
        .INIT  (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_nx;
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= usr_addr;
            wdata_q <= usr_wdata;
            mask_q  <= usr_mask;
        end
    end

    // read capture on the last read cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usr_rdata  <= '0;
            usr_rvalid <= 1'b0;
        end else begin
            usr_rvalid <= (state_q == ST_READ) && tmr_done;
            if ((state_q == ST_READ) && tmr_done) usr_rdata <= din_kept;
        end
    end

    sram_ctl_lanes #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .active   (lane_act),
        .mask     (mask_q),
        .din      (mem_din),
        .lane_n   (mem_lane_n),
        .din_kept (din_kept)
    );

    // strobes decoded from the state register
    always_comb begin
        mem_cs_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_dout_en = 1'b0;
        lane_act    = 1'b0;
        usr_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: usr_ready = 1'b1;
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                lane_act = 1'b1;
            end
            ST_WPULSE: begin
                mem_cs_n    = 1'b0;
                mem_we_n    = 1'b0;
                mem_dout_en = 1'b1;
                lane_act    = 1'b1;
            end
            ST_WHOLD: begin
                mem_cs_n    = 1'b0;
                mem_dout_en = 1'b1;
                lane_act    = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_ready,
    input logic              usr_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);

    // R7
    drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    // R4
    wpulse_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dout_en));

    // R5
    whold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dout_en && !mem_cs_n && $stable(mem_addr)
                             && $stable(mem_dout) && $stable(mem_lane_n)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en
                       && (mem_lane_n == '1)));

    // R2
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rvalid |=> !usr_rvalid);

    // R2
    read_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    // R7
    rvalid_in_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rvalid |-> (!usr_ready && mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .usr_ready   (usr_ready),
    .usr_rvalid  (usr_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_lane_n  (mem_lane_n),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

    localparam int PWR  = 12500;  // 100 us / 8 ns
    localparam int RD   = 2;      // ceil(10/8)
    localparam int TURN = 1;      // ceil(5/8)
    localparam int WP   = 1;      // ceil(7/8)
    localparam int WH   = 1;      // max(1, ceil(10/8) - WP)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usr_req = 1'b0, usr_we = 1'b0;
    logic [16:0] usr_addr = '0;
    logic [15:0] usr_wdata = '0;
    logic [1:0]  usr_mask = '0;
    logic        usr_ready, usr_rvalid;
    logic [15:0] usr_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = 16'hBAD0;

    int total = 0, bad = 0;
    int v_conflict = 0, v_wlen = 0, v_hold = 0, v_turn = 0, v_rlen = 0;

    always #4 clk = ~clk;

    sram_ctl dut (.*);

    logic [15:0] sram   [int];  // memory model content
    logic [15:0] shadow [int];  // expected content

    // memory model: pins settle right after the edge
    always @(posedge clk) begin
        #1;
        if (!mem_cs_n && !mem_we_n) begin
            logic [15:0] cur;
            cur = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
            if (!mem_lane_n[0]) cur[7:0]  = mem_dout[7:0];
            if (!mem_lane_n[1]) cur[15:8] = mem_dout[15:8];
            sram[int'(mem_addr)] = cur;
        end
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            logic [15:0] cur;
            cur = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
            mem_din[7:0]  <= mem_lane_n[0] ? 8'hEE : cur[7:0];
            mem_din[15:8] <= mem_lane_n[1] ? 8'hEE : cur[15:8];
        end else begin
            mem_din <= 16'hBAD0;
        end
    end

    // pin monitor
    int          we_run = 0, oe_run = 0, oe_gap = 0;
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_den = 1'b0;
    logic [16:0] p_addr = '0;
    logic [15:0] p_dout = '0;
    logic [1:0]  p_lane = '1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dout_en && !mem_oe_n) v_conflict++;           // R7
            if (!mem_we_n) we_run++;
            if (mem_we_n && !p_we_n) begin
                if (we_run < WP) v_wlen++;                        // R4
                if (!(mem_dout_en && !mem_cs_n && mem_addr == p_addr &&
                      mem_dout == p_dout && mem_lane_n == p_lane)) v_hold++;  // R5
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            if (mem_oe_n && !p_oe_n) begin
                if (oe_run != RD) v_rlen++;                       // R2
                oe_run = 0;
            end
            if (mem_dout_en && !p_den && oe_gap < TURN) v_turn++; // R7
            if (!mem_oe_n) oe_gap = 0; else if (!mem_dout_en) oe_gap++;
        end
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_den = mem_dout_en;
        p_addr = mem_addr; p_dout = mem_dout; p_lane = mem_lane_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [16:0] a, input logic [1:0] m);
        logic [15:0] v;
        v = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    // called at a negedge; returns at a negedge with usr_ready high
    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        int lat;
        usr_req = 1'b1; usr_we = 1'b1; usr_addr = a; usr_wdata = d; usr_mask = m;
        while (!usr_ready) @(negedge clk);
        @(negedge clk);
        usr_req = 1'b0;
        shadow[int'(a)] = merge(shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0, d, m);
        lat = 1;
        while (!usr_ready) begin @(negedge clk); lat++; end
        chk(lat == WP + WH + 1, "R5 write busy length", lat, WP + WH + 1);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [1:0] m, input string tag);
        int lat;
        logic [15:0] e;
        e = exp_read(a, m);
        usr_req = 1'b1; usr_we = 1'b0; usr_addr = a; usr_mask = m;
        while (!usr_ready) @(negedge clk);
        @(negedge clk);
        usr_req = 1'b0;
        lat = 1;
        while (!usr_rvalid) begin @(negedge clk); lat++; end
        chk(lat == RD + 1, "R2 read latency", lat, RD + 1);
        chk(usr_rdata == e, tag, usr_rdata, e);
        while (!usr_ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int pw_bad;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!usr_ready && !usr_rvalid, "R10 ready/rvalid in reset", {usr_ready, usr_rvalid}, 0);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en, "R10 strobes in reset",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b1110);
        rst_n = 1'b1;
        // R1 power-up hold-off
        n = 0; pw_bad = 0;
        while (!usr_ready) begin
            @(negedge clk); n++;
            if (!usr_ready && !(mem_cs_n && mem_oe_n && mem_we_n)) pw_bad++;
        end
        chk(n == PWR, "R1 power-up edges", n, PWR);
        chk(pw_bad == 0, "R1 strobes idle during hold-off", pw_bad, 0);
        // R9 idle outputs
        chk(mem_lane_n == 2'b11 && !mem_dout_en && mem_cs_n, "R9 idle quiet",
            {mem_lane_n, mem_dout_en, mem_cs_n}, 4'b1101);

        // R4 R2 full word write and read back
        do_write(17'h00005, 16'hA55A, 2'b11);
        do_read(17'h00005, 2'b11, "R2 full read-back");
        // R6 low lane only write keeps high byte
        do_write(17'h00005, 16'h1234, 2'b01);
        do_read(17'h00005, 2'b11, "R6 low lane write");
        do_write(17'h1FFFF, 16'hC3E1, 2'b10);
        do_read(17'h1FFFF, 2'b11, "R6 high lane write at top address");
        // R3 lane-masked reads
        do_read(17'h00005, 2'b10, "R3 high lane read, low zero");
        do_read(17'h00005, 2'b01, "R3 low lane read, high zero");
        do_read(17'h00005, 2'b00, "R3 no lane read");

        // R8 request while busy is ignored
        usr_req = 1'b1; usr_we = 1'b1; usr_addr = 17'h00009; usr_wdata = 16'h7777; usr_mask = 2'b11;
        while (!usr_ready) @(negedge clk);
        @(negedge clk);
        shadow[9] = 16'h7777;
        chk(!usr_ready, "R8 ready low while busy", usr_ready, 0);
        usr_addr = 17'h0000A; usr_wdata = 16'hDEAD;
        @(negedge clk);
        chk(mem_addr == 17'h00009, "R8 bus address kept", mem_addr, 17'h00009);
        usr_req = 1'b0;
        while (!usr_ready) @(negedge clk);
        do_read(17'h0000A, 2'b11, "R8 ignored request left memory untouched");
        do_read(17'h00009, 2'b11, "R8 accepted write stored");

        // R7 read followed at once by writes (turnaround meets next accept)
        for (int i = 0; i < 4; i++) begin
            do_read(17'h00009, 2'b11, "R7 read before write");
            do_write(17'h00009, 16'(16'h0101 * (i + 1)), 2'b11);
        end

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            logic [15:0] d;
            logic [1:0]  m;
            a = ($urandom % 2 == 1) ? (17'h1FFF0 | 17'($urandom % 16)) : 17'($urandom % 16);
            d = 16'($urandom);
            m = 2'($urandom);
            if ($urandom % 2 == 1) do_write(a, d, m);
            else do_read(a, m, "R2 R3 R6 random read");
        end

        @(negedge clk);
        chk(v_conflict == 0, "R7 drive while output enabled", v_conflict, 0);
        chk(v_turn == 0, "R7 turnaround gap", v_turn, 0);
        chk(v_wlen == 0, "R4 write pulse length", v_wlen, 0);
        chk(v_hold == 0, "R5 hold after write", v_hold, 0);
        chk(v_rlen == 0, "R2 read phase length", v_rlen, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule